// File: doc/BRIEF.md
# PCI Type-0 Configuration Space Target

This block is the configuration register file of a PCI endpoint with one function. Configuration cycles reach it through a plain access port. The port carries a select, a read/write flag, a 6-bit dword index covering the 256-byte space, four byte enables and 32-bit write data. Read data comes back in the same cycle. The lower 16 dwords form the standard type-0 header. That header holds the fixed identity words, the command word, six base address registers (BARs) and the interrupt line/pin pair. A parameterised run of scratch dwords starts at dword 16.

Parameters describe each BAR slot. A slot can be unused, a 32-bit memory window, the lower half of a 64-bit memory window, or an I/O window. Each slot also has a size given as a power of two and a prefetchable flag. Firmware sizes a window by writing all ones to the BAR and reading back the mask. It then writes the assigned base. After that, the block flags every incoming memory or I/O address that lands inside a programmed window, but only once the matching decode enable in the command word is set.

Top module: `cfg_space_target`

## Requirements
- R1: Dword 0 reads {device id, vendor id} and dword 2 reads {24-bit class code, revision}, all taken from parameters. Writes to these dwords have no effect.
- R2: Byte enable bit k controls write data bits 8k+7:8k, which is byte address 4*index+k. A write changes only the enabled bytes of writable fields.
- R3: In dword 1, bit 0 is the I/O decode enable and bit 1 is the memory decode enable. Both are writable through byte enable 0. All other bits of dword 1 read 0.
- R4: The BAR at dword 4+i stores only the address bits at or above its size. After all ones are written, a read returns the size mask with the type bits set. The type bits are: memory bit 0 = 0, bits 2:1 = 00 for 32-bit or 10 for 64-bit, and bit 3 = prefetchable. I/O bits 1:0 read 01.
- R5: The slot after a 64-bit memory BAR holds address bits 63:32 and is fully writable.
- R6: Byte 0x3C (dword 15, bits 7:0) is a read/write interrupt line. Byte 0x3D (bits 15:8) reads the fixed interrupt pin value and ignores writes. Bits 31:16 read 0.
- R7: Unused BAR slots, dword 3, dwords 10 to 14 and dwords past the scratch area read 0 and ignore writes.
- R8: Dwords 16 to 16+SCRATCH_DWORDS-1 are plain read/write storage.
- R9: mem_hit[i] is 1 when the memory enable is set and the masked address matches BAR i. A 64-bit pair compares all 64 bits. A 32-bit BAR requires address bits 63:32 to be zero.
- R10: io_hit[i] is 1 when the I/O enable is set and the 32-bit I/O address, masked by the slot size, matches I/O BAR i.
- R11: After reset, the command word, the BARs, the interrupt line and the scratch area are all zero, and no hit output is set.
- R12: cfg_rdata shows the indexed dword while cfg_sel is 1 and cfg_wr is 0, and reads zero at all other times. A write takes effect at the clock edge on which cfg_sel and cfg_wr are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Configuration access select |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | 6 | Dword index into the 256-byte space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (same cycle) |
| mem_addr | input | 64 | Memory address to decode |
| io_addr | input | 32 | I/O address to decode |
| mem_hit | output | 6 | Per-slot memory window hit |
| io_hit | output | 6 | Per-slot I/O window hit |

## Verification
The bench aims at the size probe, where a BAR that stored its low address bits would read back a value other than the mask plus flags. It also covers partial byte-enable writes, which a design ignoring enables would spread into neighbouring bytes. For the 64-bit pair it drives addresses whose low word matches but whose upper word does not; a design comparing only 32 bits would raise a false hit there. Addresses inside a window are also driven with the decode enable clear, where a design that does not gate on the enable would flag a hit. Random write/read traffic over the whole index range checks that the read-only and reserved locations hold their values.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

   localparam int NUM_BARS  = 6;
   localparam int IDX_W     = 6;
   localparam int IDX_ID    = 0;
   localparam int IDX_CMD   = 1;
   localparam int IDX_CLASS = 2;
   localparam int IDX_BAR0  = 4;
   localparam int IDX_INTR  = 15;
   localparam int IDX_SCR0  = 16;

   typedef enum logic [2:0] {
      BK_NONE     = 3'd0,
      BK_MEM32    = 3'd1,
      BK_MEM64    = 3'd2,
      BK_MEM64_HI = 3'd3,
      BK_IO       = 3'd4
   } bar_kind_e;

   // declaration codes per slot: 0 unused, 1 mem32, 2 mem64 (takes next slot), 3 io
   function automatic bar_kind_e slot_kind(logic [2*NUM_BARS-1:0] decl, int i);
      logic [1:0] code;
      code = decl[2*i +: 2];
      if (i > 0 && decl[2*(i-1) +: 2] == 2'd2) return BK_MEM64_HI;
      case (code)
         2'd1:    return BK_MEM32;
         2'd2:    return BK_MEM64;
         2'd3:    return BK_IO;
         default: return BK_NONE;
      endcase
   endfunction

   function automatic logic [31:0] byte_mask(logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
   import cfgspace_pkg::*;
#(
   parameter bar_kind_e KIND      = BK_NONE,
   parameter int        SIZE_LOG2 = 12,
   parameter bit        PREF      = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stb,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   input  logic [31:0] hi_word,
   input  logic        mem_en,
   input  logic        io_en,
   input  logic [63:0] mem_addr,
   input  logic [31:0] io_addr,
   output logic [31:0] base_q,
   output logic [31:0] rd_val,
   output logic        mem_hit,
   output logic        io_hit
);
   localparam bit IS_MEM = (KIND == BK_MEM32) || (KIND == BK_MEM64);
   localparam bit IS_IO  = (KIND == BK_IO);
   localparam logic [31:0] SIZE_MASK =
      (KIND == BK_NONE)     ? 32'h0 :
      (KIND == BK_MEM64_HI) ? 32'hFFFF_FFFF :
                              ~((32'h1 << SIZE_LOG2) - 32'h1);
   localparam logic [31:0] TYPE_BITS =
      IS_IO ? 32'h1 : ((KIND == BK_MEM64) ? 32'h4 : 32'h0);
   localparam logic [31:0] FLAG_BITS =
      TYPE_BITS | ((IS_MEM && PREF) ? 32'h8 : 32'h0);

   generate
      if (IS_MEM && (SIZE_LOG2 < 4 || SIZE_LOG2 > 31)) begin : g_bad_mem_size
         $error("memory BAR size exponent must lie in 4..31");
      end
      if (IS_IO && (SIZE_LOG2 < 2 || SIZE_LOG2 > 31)) begin : g_bad_io_size
         $error("I/O BAR size exponent must lie in 2..31");
      end
   endgenerate

   logic [31:0] wmask;
   logic        upper_ok;

   assign wmask = byte_mask(be) & SIZE_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n)      base_q <= '0;
      else if (wr_stb) base_q <= (base_q & ~wmask) | (wdata & wmask);
   end

   assign upper_ok = (KIND == BK_MEM64) ? (mem_addr[63:32] == hi_word)
                                        : (mem_addr[63:32] == 32'h0);
   assign mem_hit  = IS_MEM && mem_en && upper_ok &&
                     ((mem_addr[31:0] & SIZE_MASK) == base_q);
   assign io_hit   = IS_IO && io_en && ((io_addr & SIZE_MASK) == base_q);
   assign rd_val   = base_q | FLAG_BITS;

endmodule

// File: rtl/cfg_ctl_regs.sv
module cfg_ctl_regs
   import cfgspace_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic             be0,
   input  logic [7:0]       wbyte,
   output logic             io_en,
   output logic             mem_en,
   output logic [7:0]       int_line
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_en    <= 1'b0;
         mem_en   <= 1'b0;
         int_line <= 8'h0;
      end else if (wr && be0) begin
         if (idx == IDX_W'(IDX_CMD)) begin
            io_en  <= wbyte[0];
            mem_en <= wbyte[1];
         end
         if (idx == IDX_W'(IDX_INTR)) int_line <= wbyte;
      end
   end
endmodule

// File: rtl/cfg_scratch.sv
module cfg_scratch
   import cfgspace_pkg::*;
#(
   parameter int DWORDS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [3:0]       be,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd_val
);
   generate
      if (DWORDS < 1 || DWORDS > (1 << IDX_W) - IDX_SCR0) begin : g_bad_depth
         $error("scratch depth must fit between dword 16 and the end of the space");
      end
   endgenerate

   logic [31:0] store [DWORDS];
   logic [31:0] bmask;

   assign bmask = byte_mask(be);

   for (genvar d = 0; d < DWORDS; d++) begin : g_dw
      always_ff @(posedge clk) begin
         if (!rst_n) store[d] <= '0;
         else if (wr && idx == IDX_W'(IDX_SCR0 + d))
            store[d] <= (store[d] & ~bmask) | (wdata & bmask);
      end
   end

   always_comb begin
      rd_val = '0;
      for (int d = 0; d < DWORDS; d++)
         if (idx == IDX_W'(IDX_SCR0 + d)) rd_val = store[d];
   end
endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target
   import cfgspace_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID     = 16'hA5C3,
   parameter logic [15:0] DEVICE_ID     = 16'h0B17,
   parameter logic [23:0] CLASS_CODE    = 24'h058000,
   parameter logic [7:0]  REVISION_ID   = 8'h02,
   parameter logic [7:0]  INT_PIN       = 8'h01,
   parameter logic [2*NUM_BARS-1:0] BAR_DECL = {2'd0, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1},
   parameter logic [8*NUM_BARS-1:0] BAR_SIZE_LOG2 = {8'd0, 8'd0, 8'd0, 8'd20, 8'd8, 8'd12},
   parameter logic [NUM_BARS-1:0]   BAR_PREF = 6'b000100,
   parameter int          SCRATCH_DWORDS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_sel,
   input  logic                cfg_wr,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [3:0]          cfg_be,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic [63:0]         mem_addr,
   input  logic [31:0]         io_addr,
   output logic [NUM_BARS-1:0] mem_hit,
   output logic [NUM_BARS-1:0] io_hit
);
   generate
      if (INT_PIN > 8'd4) begin : g_bad_pin
         $error("interrupt pin value must be 0..4");
      end
   endgenerate

   logic        wr_any;
   logic        io_en;
   logic        mem_en;
   logic [7:0]  int_line;
   logic [31:0] scratch_rd;
   logic [31:0] bar_base [NUM_BARS+1];
   logic [31:0] bar_rd   [NUM_BARS];

   assign wr_any             = cfg_sel && cfg_wr;
   assign bar_base[NUM_BARS] = '0;

   cfg_ctl_regs u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_any),
      .idx      (cfg_idx),
      .be0      (cfg_be[0]),
      .wbyte    (cfg_wdata[7:0]),
      .io_en    (io_en),
      .mem_en   (mem_en),
      .int_line (int_line)
   );

   cfg_scratch #(.DWORDS(SCRATCH_DWORDS)) u_scratch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_any),
      .idx    (cfg_idx),
      .be     (cfg_be),
      .wdata  (cfg_wdata),
      .rd_val (scratch_rd)
   );

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      localparam bar_kind_e KIND = slot_kind(BAR_DECL, i);

      if (BAR_DECL[2*i +: 2] == 2'd2) begin : g_pair_chk
         if (i == NUM_BARS - 1) begin : g_last
            $error("a 64-bit BAR cannot use the last slot");
         end else if (BAR_DECL[2*(i+1) +: 2] != 2'd0) begin : g_taken
            $error("slot after a 64-bit BAR must be declared unused");
         end
      end

      cfg_bar_slot #(
         .KIND      (KIND),
         .SIZE_LOG2 (int'(BAR_SIZE_LOG2[8*i +: 8])),
         .PREF      (BAR_PREF[i])
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_stb   (wr_any && cfg_idx == IDX_W'(IDX_BAR0 + i)),
         .be       (cfg_be),
         .wdata    (cfg_wdata),
         .hi_word  (bar_base[i+1]),
         .mem_en   (mem_en),
         .io_en    (io_en),
         .mem_addr (mem_addr),
         .io_addr  (io_addr),
         .base_q   (bar_base[i]),
         .rd_val   (bar_rd[i]),
         .mem_hit  (mem_hit[i]),
         .io_hit   (io_hit[i])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_sel && !cfg_wr) begin
         if (cfg_idx == IDX_W'(IDX_ID))    cfg_rdata = {DEVICE_ID, VENDOR_ID};
         if (cfg_idx == IDX_W'(IDX_CMD))   cfg_rdata = {30'h0, mem_en, io_en};
         if (cfg_idx == IDX_W'(IDX_CLASS)) cfg_rdata = {CLASS_CODE, REVISION_ID};
         if (cfg_idx == IDX_W'(IDX_INTR))  cfg_rdata = {16'h0, INT_PIN, int_line};
         for (int b = 0; b < NUM_BARS; b++)
            if (cfg_idx == IDX_W'(IDX_BAR0 + b)) cfg_rdata = bar_rd[b];
         cfg_rdata = cfg_rdata | scratch_rd;
      end
   end

endmodule

// File: rtl/cfg_space_target_chk.sv
module cfg_space_target_chk
   import cfgspace_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID      = 16'h0,
   parameter logic [15:0] DEVICE_ID      = 16'h0,
   parameter int          SCRATCH_DWORDS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_sel,
   input logic                cfg_wr,
   input logic [IDX_W-1:0]    cfg_idx,
   input logic [31:0]         cfg_rdata,
   input logic [NUM_BARS-1:0] mem_hit,
   input logic [NUM_BARS-1:0] io_hit,
   input logic                io_en,
   input logic                mem_en
);
   // R9
   mem_hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|mem_hit) |-> mem_en);

   // R10
   io_hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|io_hit) |-> io_en);

   // R3
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_sel && cfg_wr && cfg_idx == IDX_W'(IDX_CMD)) |=> $stable({io_en, mem_en}));

   // R1
   ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel && !cfg_wr && cfg_idx == IDX_W'(IDX_ID)) |-> cfg_rdata == {DEVICE_ID, VENDOR_ID});

   // R7
   reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel && !cfg_wr && (cfg_idx == 6'd3 || int'(cfg_idx) >= IDX_SCR0 + SCRATCH_DWORDS))
      |-> cfg_rdata == 32'h0);

   // R12
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_sel && !cfg_wr) |-> cfg_rdata == 32'h0);
endmodule

bind cfg_space_target cfg_space_target_chk #(
   .VENDOR_ID      (VENDOR_ID),
   .DEVICE_ID      (DEVICE_ID),
   .SCRATCH_DWORDS (SCRATCH_DWORDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_sel   (cfg_sel),
   .cfg_wr    (cfg_wr),
   .cfg_idx   (cfg_idx),
   .cfg_rdata (cfg_rdata),
   .mem_hit   (mem_hit),
   .io_hit    (io_hit),
   .io_en     (io_en),
   .mem_en    (mem_en)
);

// File: tb/cfg_space_target_test.sv
`timescale 1ns/1ps
module cfg_space_target_test;
   localparam logic [15:0] VEN = 16'hA5C3;
   localparam logic [15:0] DEV = 16'h0B17;
   localparam logic [31:0] CLS = 32'h0580_0002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sel = 1'b0, cfg_wr = 1'b0;
   logic [5:0]  cfg_idx = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [63:0] mem_addr = '0;
   logic [31:0] io_addr = '0;
   logic [5:0]  mem_hit, io_hit;

   int total = 0, bad = 0;
   logic [31:0] m [64];

   always #2.5 clk = ~clk;

   cfg_space_target uut (.*);

   function automatic logic [31:0] wmask(int idx);
      case (idx)
         1:  return 32'h0000_0003;
         4:  return 32'hFFFF_F000;
         5:  return 32'hFFFF_FF00;
         6:  return 32'hFFF0_0000;
         7:  return 32'hFFFF_FFFF;
         15: return 32'h0000_00FF;
         default: return (idx >= 16 && idx < 24) ? 32'hFFFF_FFFF : 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] fixed_bits(int idx);
      case (idx)
         0:  return {DEV, VEN};
         2:  return CLS;
         5:  return 32'h1;
         6:  return 32'hC;
         15: return 32'h0000_0100;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(int idx);
      case (idx)
         0, 2:    return "R1";
         1:       return "R3";
         4, 5, 6: return "R4";
         7:       return "R5";
         15:      return "R6";
         default: return (idx >= 16 && idx < 24) ? "R8" : "R7";
      endcase
   endfunction

   function automatic logic [5:0] exp_mem_hit(logic [63:0] a);
      logic [5:0] h = '0;
      if (m[1][1]) begin
         h[0] = (a[63:32] == 32'h0) && ((a[31:0] & 32'hFFFF_F000) == m[4]);
         h[2] = (a[63:32] == m[7]) && ((a[31:0] & 32'hFFF0_0000) == m[6]);
      end
      return h;
   endfunction

   function automatic logic [5:0] exp_io_hit(logic [31:0] a);
      return {4'h0, m[1][0] && ((a & 32'hFFFF_FF00) == m[5]), 1'b0};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(int idx, logic [3:0] be, logic [31:0] d);
      logic [31:0] k;
      @(negedge clk);
      cfg_sel = 1; cfg_wr = 1; cfg_idx = 6'(idx); cfg_be = be; cfg_wdata = d;
      #1 check("R12", cfg_rdata, 32'h0);
      @(posedge clk);
      k = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & wmask(idx);
      m[idx] = (m[idx] & ~k) | (d & k);
      @(negedge clk);
      cfg_sel = 0; cfg_wr = 0;
   endtask

   task automatic cfg_read(int idx, output logic [31:0] d);
      @(negedge clk);
      cfg_sel = 1; cfg_wr = 0; cfg_idx = 6'(idx);
      #1 d = cfg_rdata;
      @(negedge clk);
      cfg_sel = 0;
      #1 check("R12", cfg_rdata, 32'h0);
   endtask

   task automatic read_chk(int idx, string tag);
      logic [31:0] d;
      cfg_read(idx, d);
      check(tag, d, m[idx] | fixed_bits(idx));
   endtask

   task automatic hit_chk(logic [63:0] ma, logic [31:0] ia, string tag);
      @(negedge clk);
      mem_addr = ma; io_addr = ia;
      #1;
      check(tag, {26'h0, mem_hit}, {26'h0, exp_mem_hit(ma)});
      check(tag, {26'h0, io_hit}, {26'h0, exp_io_hit(ia)});
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int unsigned seed;
      seed = $urandom(32'd20240611);
      for (int i = 0; i < 64; i++) m[i] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R11 reset state
      #1 check("R12", cfg_rdata, 32'h0);
      check("R11", {26'h0, mem_hit | io_hit}, 32'h0);
      for (int i = 0; i < 24; i++) read_chk(i, "R11");

      // R1 identity ignores writes
      cfg_write(0, 4'hF, 32'hFFFF_FFFF); read_chk(0, "R1");
      cfg_write(2, 4'hF, 32'h1234_5678); read_chk(2, "R1");

      // R2 byte enables on scratch
      cfg_write(16, 4'hF, 32'h1122_3344);
      cfg_write(16, 4'b0101, 32'hAABB_CCDD);
      cfg_read(16, d); check("R2", d, 32'h11BB_33DD);

      // R6 pin byte read-only, line writable
      cfg_write(15, 4'b0010, 32'h0000_5500); read_chk(15, "R6");
      cfg_write(15, 4'hF, 32'hFFFF_FF3A);
      cfg_read(15, d); check("R6", d, 32'h0000_013A);

      // R4 and R5 size probes
      for (int i = 4; i < 8; i++) cfg_write(i, 4'hF, 32'hFFFF_FFFF);
      cfg_read(4, d); check("R4", d, 32'hFFFF_F000);
      cfg_read(5, d); check("R4", d, 32'hFFFF_FF01);
      cfg_read(6, d); check("R4", d, 32'hFFF0_000C);
      cfg_read(7, d); check("R5", d, 32'hFFFF_FFFF);

      // R7 unused slot and reserved dwords
      cfg_write(8, 4'hF, 32'hFFFF_FFFF); cfg_read(8, d); check("R7", d, 32'h0);
      cfg_write(40, 4'hF, 32'hDEAD_BEEF); cfg_read(40, d); check("R7", d, 32'h0);
      cfg_write(3, 4'hF, 32'hDEAD_BEEF); cfg_read(3, d); check("R7", d, 32'h0);

      // program windows, decode disabled
      cfg_write(4, 4'hF, 32'h8000_0000);
      cfg_write(5, 4'hF, 32'h0000_C100);
      cfg_write(6, 4'hF, 32'h4010_0000);
      cfg_write(7, 4'hF, 32'h0000_0002);
      hit_chk(64'h0000_0000_8000_0ABC, 32'h0000_C1FF, "R9");
      check("R9", {26'h0, mem_hit}, 32'h0);
      check("R10", {26'h0, io_hit}, 32'h0);
      // R3 memory enable only
      cfg_write(1, 4'hF, 32'hFFFF_FFFE); read_chk(1, "R3");
      hit_chk(64'h0000_0000_8000_0ABC, 32'h0000_C1FF, "R9");
      check("R9", {26'h0, mem_hit}, 32'h1);
      check("R10", {26'h0, io_hit}, 32'h0);
      hit_chk(64'h0000_0000_8000_1000, 32'h0, "R9");
      hit_chk(64'h0000_0002_4010_0FFF, 32'h0, "R9");
      check("R9", {26'h0, mem_hit}, 32'h4);
      hit_chk(64'h0000_0000_4010_0000, 32'h0, "R9");
      check("R9", {26'h0, mem_hit}, 32'h0);
      hit_chk(64'h0000_0001_8000_0000, 32'h0, "R9");
      check("R9", {26'h0, mem_hit}, 32'h0);
      cfg_write(1, 4'h1, 32'h0000_0003);
      hit_chk(64'h0, 32'h0000_C1FF, "R10");
      check("R10", {26'h0, io_hit}, 32'h2);
      hit_chk(64'h0, 32'h0000_C200, "R10");

      // constrained random traffic
      for (int it = 0; it < 1500; it++) begin
         int idx;
         logic [31:0] dat;
         if ($urandom % 2) begin
            int pick = $urandom % 12;
            idx = (pick < 8) ? 16 + pick : ((pick == 8) ? 1 : ((pick == 9) ? 15 : 4 + ($urandom % 4)));
         end else idx = $urandom % 64;
         dat = ($urandom % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
         case ($urandom % 3)
            0: cfg_write(idx, 4'($urandom), dat);
            1: read_chk(idx, tag_of(idx));
            default: begin
               logic [63:0] ma;
               logic [31:0] ia;
               ma = ($urandom % 2) ? {m[7], m[6] | ($urandom & 32'h000F_FFFF)}
                                   : {32'($urandom % 2), m[4] | ($urandom & 32'h1FFF)};
               ia = m[5] | ($urandom & 32'h1FF);
               hit_chk(ma, ia, "R9");
            end
         endcase
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule